// File: doc/BRIEF.md
# Block Write-Protection and Status Register

This block holds the protection state of a serial non-volatile memory: a write-enable latch, a two-bit protected-range selector and a bit that lets an external write-protect pin lock the configuration. From this state, the protect pin and a candidate array address, it produces two permits. One says whether the array location may be programmed. The other says whether the status register itself may be rewritten. It also assembles the byte that a status read returns.

A command decoder drives the block with one-cycle strobes: set the enable, clear the enable, and request a status write that carries its data byte. It also drives a chip-select activity level. The write controller supplies the busy flag and a cycle-done strobe. A status write is captured during the transaction and takes effect only when chip select goes inactive. It is dropped if the protect pin locks the register before then. The protection bits live in ordinary flops and do not survive loss of power.

Top module: `wprot_status_ctrl`

## Requirements
- R1: After reset the enable latch, both range bits and the pin-lock enable bit are 0, so the status byte reads 0x00 and both permits are 0.
- R2: A set strobe makes the enable bit 1 and a clear strobe makes it 0, whatever the protect pin does. When both arrive in the same cycle, clear wins.
- R3: The status byte has the pin-lock enable bit at bit 7, range bits at 3:2 (high at 3), the enable bit at 1 and the busy bit at 0. Bits 6:4 and bit 0 read 0 when idle. All eight bits read 1 while busy_i is high.
- R4: A status-write request is accepted while chip select is active and the status permit is 1. It is applied on the cycle in which chip select goes inactive. It changes only bits 7, 3 and 2, and sr_commit_o pulses for one cycle right after that.
- R5: Range code 00 protects nothing. Code 01 protects the top quarter, where the two address MSBs are 11. Code 10 protects the top half, where the address MSB is 1. Code 11 protects the whole array.
- R6: arr_wr_ok_o is 1 exactly when the enable bit is 1 and the address is outside the protected range. It follows addr_i in the same cycle.
- R7: sr_wr_ok_o is 1 exactly when the enable bit is 1 and either the pin-lock enable bit is 0 or wp_n_i is high. While that bit is 1 and wp_n_i is low, it cannot be cleared.
- R8: A captured status write is discarded if wp_n_i goes low while chip select is still active and the pin-lock enable bit is 1. A write already applied is not affected by later pin changes.
- R9: While busy_i is high, set strobes, clear strobes and status-write requests have no effect.
- R10: cyc_done_i clears the enable bit, even while busy, and wins over a set strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wen_set_i | input | 1 | Enable-set strobe |
| wen_clr_i | input | 1 | Enable-clear strobe |
| sr_wr_req_i | input | 1 | Status-write request strobe |
| sr_wdata_i | input | 8 | Status-write data byte |
| cs_act_i | input | 1 | Chip select active (1 = selected) |
| wp_n_i | input | 1 | Write-protect pin, low = protect |
| busy_i | input | 1 | Internal write cycle in progress |
| cyc_done_i | input | 1 | Write cycle finished strobe |
| addr_i | input | ADDR_W | Candidate array address |
| status_o | output | 8 | Status byte for reads |
| arr_wr_ok_o | output | 1 | Array write permitted at addr_i |
| sr_wr_ok_o | output | 1 | Status write permitted |
| sr_commit_o | output | 1 | Status write applied (one-cycle pulse) |

## Verification
The permits are combinational on the current state and inputs, so the bench samples them in the same cycle the address or pin is driven. Strobes and the busy-gated requests reach the state flops at the next rising edge, so their effect on status_o is checked one cycle later. A status write becomes visible, together with the sr_commit_o pulse, one cycle after chip select is dropped. All inputs change on falling edges and outputs are sampled at the following falling edge, so each check sits exactly at its due cycle. The sr_commit_o check is placed on that cycle and the one after it, so a late or stretched pulse is caught.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  localparam int unsigned SR_W        = 8;
  localparam int unsigned SR_LOCK_BIT = 7;
  localparam int unsigned SR_RNG_HI   = 3;
  localparam int unsigned SR_RNG_LO   = 2;
  localparam int unsigned SR_EN_BIT   = 1;
  localparam int unsigned SR_BSY_BIT  = 0;

  typedef enum logic [1:0] {
    RNG_NONE = 2'b00,
    RNG_QTR  = 2'b01,
    RNG_HALF = 2'b10,
    RNG_ALL  = 2'b11
  } rng_lvl_e;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] rng;
  } cfg_t;

endpackage

// File: rtl/wprot_rst_sync.sv
module wprot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/wprot_range_dec.sv
module wprot_range_dec
  import wprot_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  rng_lvl_e          lvl_i,
  output logic              prot_o
);
  localparam int unsigned MSB = ADDR_W - 1;

  logic [1:0] top2;
  logic [ADDR_W-3:0] unused_low;

  assign top2       = addr_i[MSB -: 2];
  assign unused_low = addr_i[ADDR_W-3:0];

  always_comb begin
    unique case (lvl_i)
      RNG_NONE: prot_o = 1'b0;
      RNG_QTR:  prot_o = (top2 == 2'b11);
      RNG_HALF: prot_o = top2[1];
      RNG_ALL:  prot_o = 1'b1;
      default:  prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wprot_wen_latch.sv
module wprot_wen_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic done_i,
  input  logic busy_i,
  output logic wen_o
);
  logic wen_q, wen_d, wen_upd;

  always_comb begin
    wen_upd = 1'b0;
    wen_d   = wen_q;
    if (done_i) begin
      wen_upd = 1'b1;
      wen_d   = 1'b0;
    end else if (!busy_i && clr_i) begin
      wen_upd = 1'b1;
      wen_d   = 1'b0;
    end else if (!busy_i && set_i) begin
      wen_upd = 1'b1;
      wen_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wen_q <= 1'b0;
    else if (wen_upd) wen_q <= wen_d;
  end

  assign wen_o = wen_q;
endmodule

// File: rtl/wprot_sr_commit.sv
module wprot_sr_commit
  import wprot_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_act_i,
  input  logic           wp_n_i,
  input  logic           busy_i,
  input  logic           req_i,
  input  logic [SR_W-1:0] wdata_i,
  input  logic           permit_i,
  output cfg_t           cfg_o,
  output logic           commit_o
);
  cfg_t cfg_q, cfg_d, pend_cfg_q, pend_cfg_d;
  logic pend_q, pend_d;
  logic cs_q;
  logic commit_q;
  logic hw_lock, accept, cancel, cs_fall, commit;
  logic [2:0] unused_wdata;
  logic [1:0] unused_wdata_lo;

  assign unused_wdata    = wdata_i[6:4];
  assign unused_wdata_lo = wdata_i[SR_EN_BIT:SR_BSY_BIT];

  assign hw_lock = cfg_q.lock_en & ~wp_n_i;
  assign accept  = req_i & cs_act_i & ~busy_i & permit_i;
  assign cancel  = pend_q & cs_act_i & hw_lock;
  assign cs_fall = cs_q & ~cs_act_i;
  assign commit  = pend_q & cs_fall & ~hw_lock;

  always_comb begin
    pend_d     = pend_q;
    pend_cfg_d = pend_cfg_q;
    cfg_d      = cfg_q;
    if (!cs_act_i || cancel) begin
      pend_d = 1'b0;
    end else if (accept) begin
      pend_d             = 1'b1;
      pend_cfg_d.lock_en = wdata_i[SR_LOCK_BIT];
      pend_cfg_d.rng     = wdata_i[SR_RNG_HI:SR_RNG_LO];
    end
    if (commit) cfg_d = pend_cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= 1'b0;
      pend_q     <= 1'b0;
      pend_cfg_q <= '0;
      cfg_q      <= '0;
      commit_q   <= 1'b0;
    end else begin
      cs_q     <= cs_act_i;
      pend_q   <= pend_d;
      commit_q <= commit;
      if (accept) pend_cfg_q <= pend_cfg_d;
      if (commit) cfg_q      <= cfg_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign commit_o = commit_q;
endmodule

// File: rtl/wprot_status_ctrl.sv
module wprot_status_ctrl
  import wprot_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_set_i,
  input  logic              wen_clr_i,
  input  logic              sr_wr_req_i,
  input  logic [7:0]        sr_wdata_i,
  input  logic              cs_act_i,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic              cyc_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              arr_wr_ok_o,
  output logic              sr_wr_ok_o,
  output logic              sr_commit_o
);
  logic     rst_n_s;
  logic     wen_q;
  logic     wpen_q;
  logic     prot;
  cfg_t     cfg;
  rng_lvl_e lvl;

  wprot_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  wprot_wen_latch u_wen (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .set_i  (wen_set_i),
    .clr_i  (wen_clr_i),
    .done_i (cyc_done_i),
    .busy_i (busy_i),
    .wen_o  (wen_q)
  );

  wprot_sr_commit u_sr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cs_act_i (cs_act_i),
    .wp_n_i   (wp_n_i),
    .busy_i   (busy_i),
    .req_i    (sr_wr_req_i),
    .wdata_i  (sr_wdata_i),
    .permit_i (sr_wr_ok_o),
    .cfg_o    (cfg),
    .commit_o (sr_commit_o)
  );

  assign wpen_q = cfg.lock_en;
  assign lvl    = rng_lvl_e'(cfg.rng);

  wprot_range_dec #(.ADDR_W(ADDR_W)) u_rng (
    .addr_i (addr_i),
    .lvl_i  (lvl),
    .prot_o (prot)
  );

  assign arr_wr_ok_o = wen_q & ~prot;
  assign sr_wr_ok_o  = wen_q & (~wpen_q | wp_n_i);

  always_comb begin
    status_o = '0;
    if (busy_i) begin
      status_o = '1;
    end else begin
      status_o[SR_LOCK_BIT]         = wpen_q;
      status_o[SR_RNG_HI:SR_RNG_LO] = cfg.rng;
      status_o[SR_EN_BIT]           = wen_q;
      status_o[SR_BSY_BIT]          = 1'b0;
    end
  end
endmodule

// File: rtl/wprot_status_chk.sv
module wprot_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wen_clr_i,
  input logic       busy_i,
  input logic       cyc_done_i,
  input logic       cs_act_i,
  input logic       wp_n_i,
  input logic [7:0] status_o,
  input logic       arr_wr_ok_o,
  input logic       sr_wr_ok_o,
  input logic       sr_commit_o,
  input logic       wen_q,
  input logic       wpen_q
);
  a_r3_busy_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> status_o == 8'hFF);

  a_r3_idle_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (status_o[6:4] == 3'b000 && status_o[0] == 1'b0));

  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_clr_i && !busy_i) |=> !wen_q);

  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done_i |=> !wen_q);

  a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok_o |-> wen_q);

  a_r5_all_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && status_o[3:2] == 2'b11) |-> !arr_wr_ok_o);

  a_r7_pin_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen_q && !wp_n_i) |-> !sr_wr_ok_o);

  a_r7_lock_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen_q && !wp_n_i) |=> wpen_q);

  a_r4_commit_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    sr_commit_o |-> !$past(cs_act_i));

  a_r4_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    sr_commit_o |=> !sr_commit_o);
endmodule

bind wprot_status_ctrl wprot_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wen_clr_i   (wen_clr_i),
  .busy_i      (busy_i),
  .cyc_done_i  (cyc_done_i),
  .cs_act_i    (cs_act_i),
  .wp_n_i      (wp_n_i),
  .status_o    (status_o),
  .arr_wr_ok_o (arr_wr_ok_o),
  .sr_wr_ok_o  (sr_wr_ok_o),
  .sr_commit_o (sr_commit_o),
  .wen_q       (wen_q),
  .wpen_q      (wpen_q)
);

// File: tb/wprot_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module wprot_status_ctrl_tb_top;
  localparam int unsigned AW = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wen_set_i, wen_clr_i, sr_wr_req_i, cs_act_i, wp_n_i, busy_i, cyc_done_i;
  logic [7:0]    sr_wdata_i;
  logic [AW-1:0] addr_i;
  logic [7:0]    status_o;
  logic          arr_wr_ok_o, sr_wr_ok_o, sr_commit_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wprot_status_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wen_set_i(wen_set_i), .wen_clr_i(wen_clr_i),
    .sr_wr_req_i(sr_wr_req_i), .sr_wdata_i(sr_wdata_i), .cs_act_i(cs_act_i),
    .wp_n_i(wp_n_i), .busy_i(busy_i), .cyc_done_i(cyc_done_i), .addr_i(addr_i),
    .status_o(status_o), .arr_wr_ok_o(arr_wr_ok_o), .sr_wr_ok_o(sr_wr_ok_o),
    .sr_commit_o(sr_commit_o)
  );

  function automatic logic [7:0] exp_status(logic lk, logic [1:0] rg, logic en, logic bsy);
    if (bsy) return 8'hFF;
    return {lk, 3'b000, rg, en, 1'b0};
  endfunction

  function automatic logic exp_arr(logic en, logic [1:0] rg, logic [AW-1:0] a);
    logic p;
    case (rg)
      2'b00:   p = 1'b0;
      2'b01:   p = (a >= (3 << (AW-2)));
      2'b10:   p = (a >= (1 << (AW-1)));
      default: p = 1'b1;
    endcase
    return en && !p;
  endfunction

  function automatic logic exp_sr(logic en, logic lk, logic wpn);
    return en && (!lk || wpn);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_set();
    wen_set_i = 1'b1; step(); wen_set_i = 1'b0;
  endtask

  task automatic pulse_clr();
    wen_clr_i = 1'b1; step(); wen_clr_i = 1'b0;
  endtask

  // status write transaction; commit (if any) checked on its due cycle
  task automatic wrsr(input logic [7:0] d, input logic exp_commit);
    cs_act_i = 1'b1; step();
    sr_wr_req_i = 1'b1; sr_wdata_i = d; step();
    sr_wr_req_i = 1'b0; cs_act_i = 1'b0; step();
    chk("R4 commit pulse", sr_commit_o, exp_commit);
    step();
    chk("R4 commit one cycle", sr_commit_o, 1'b0);
  endtask

  initial begin
    while (!done && cyc < 200000) @(negedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [1:0] lv;
    void'($urandom(32'd1234));
    rst_n = 1'b0; wen_set_i = 0; wen_clr_i = 0; sr_wr_req_i = 0; sr_wdata_i = 0;
    cs_act_i = 0; wp_n_i = 1; busy_i = 0; cyc_done_i = 0; addr_i = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 status", status_o, 8'h00);
    chk("R1 arr permit", arr_wr_ok_o, 1'b0);
    chk("R1 sr permit", sr_wr_ok_o, 1'b0);

    // R2 set
    pulse_set();
    chk("R2 set", status_o, exp_status(0, 2'b00, 1, 0));
    chk("R7 sr permit wpen0", sr_wr_ok_o, exp_sr(1, 0, 1));

    // R5 R6 each range level with random addresses
    for (int l = 0; l < 4; l++) begin
      lv = 2'(l);
      wrsr({4'b0000, lv, 2'b00}, 1'b1);
      chk("R3 range field", status_o, exp_status(0, lv, 1, 0));
      for (int k = 0; k < 60; k++) begin
        addr_i = AW'($urandom);
        #1;
        chk("R5 R6 random addr", arr_wr_ok_o, exp_arr(1, lv, addr_i));
      end
      addr_i = AW'((1 << (AW-1)) - 1); #1;
      chk("R5 half boundary low", arr_wr_ok_o, exp_arr(1, lv, addr_i));
      addr_i = AW'(3 << (AW-2)); #1;
      chk("R5 quarter boundary", arr_wr_ok_o, exp_arr(1, lv, addr_i));
      addr_i = AW'((3 << (AW-2)) - 1); #1;
      chk("R5 below quarter", arr_wr_ok_o, exp_arr(1, lv, addr_i));
      step();
    end

    // R4 only bits 7,3,2 change
    wrsr(8'hFF, 1'b1);
    chk("R4 masked update", status_o, 8'h8E);

    // R7 lock: WP low with lock bit set
    wp_n_i = 1'b0; #1;
    chk("R7 sr blocked", sr_wr_ok_o, 1'b0);
    step();
    wrsr(8'h00, 1'b0);
    chk("R7 lock cannot clear", status_o, 8'h8E);
    wp_n_i = 1'b1; step();

    // R8 cancel by pin during transaction
    cs_act_i = 1'b1; step();
    sr_wr_req_i = 1'b1; sr_wdata_i = 8'h00; step();
    sr_wr_req_i = 1'b0; wp_n_i = 1'b0; step();
    wp_n_i = 1'b1; step();
    cs_act_i = 1'b0; step();
    chk("R8 cancelled no pulse", sr_commit_o, 1'b0);
    step();
    chk("R8 cancelled state", status_o, 8'h8E);

    // R8 applied write unaffected by later pin
    wrsr(8'h80, 1'b1);
    wp_n_i = 1'b0; step(); step();
    chk("R8 applied holds", status_o, 8'h82);
    wp_n_i = 1'b1; step();

    // R7 lock bit clear: pin ignored
    wrsr(8'h00, 1'b1);
    wp_n_i = 1'b0; #1;
    chk("R7 pin ignored when lock 0", sr_wr_ok_o, exp_sr(1, 0, 0));

    // R2 clear works with pin low
    pulse_clr();
    chk("R2 clear pin low", status_o, exp_status(0, 2'b00, 0, 0));
    wp_n_i = 1'b1;
    pulse_set();
    wen_set_i = 1'b1; wen_clr_i = 1'b1; step(); wen_set_i = 0; wen_clr_i = 0;
    chk("R2 clear wins", status_o, 8'h00);
    pulse_set();

    // R3 R9 busy
    busy_i = 1'b1; #1;
    chk("R3 busy ones", status_o, 8'hFF);
    pulse_clr();
    wrsr(8'h8C, 1'b0);
    busy_i = 1'b0; step();
    chk("R9 ignored while busy", status_o, 8'h02);
    busy_i = 1'b1; pulse_set(); busy_i = 1'b0;  // still enabled

    // R10 done clears, even while busy, and beats set
    busy_i = 1'b1;
    cyc_done_i = 1'b1; step(); cyc_done_i = 1'b0;
    busy_i = 1'b0; #1;
    chk("R10 done clears", status_o, 8'h00);
    wen_set_i = 1'b1; cyc_done_i = 1'b1; step(); wen_set_i = 0; cyc_done_i = 0;
    chk("R10 done beats set", status_o, 8'h00);
    addr_i = '0; #1;
    chk("R6 no enable no permit", arr_wr_ok_o, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule